// File: doc/BRIEF.md
# Counter-compare PWM generator

This block converts a binary duty word into a single pulse-width modulated bit. A free-running up-counter sweeps through all 2^WIDTH values and then wraps to zero. The wrap event sets a clocked set/reset cell, and an equality match between the counter and the duty word clears it. The output of that cell is the PWM signal. Its high time is proportional to the duty word, so a downstream averaging stage can recover a level from it.

When the duty word is all ones, the match and the wrap would both fire in the same cycle. The clear path is gated off by the wrap event, so set wins and the output stays high for the whole period. The duty word is captured once per period, on the period's last cycle. Changes made while a period is running therefore cannot cut a pulse short or stretch it. A one-cycle strobe marks the first clock of every full period.

Top module: `pwm_cmp_gen`

## Requirements
- R1: The internal counter advances by one each clock and wraps from all ones to zero, so consecutive period starts lie exactly 2^WIDTH clocks apart.
- R2: `duty_in` is captured only in the last clock of a period, when the counter is all ones, and takes effect for the next period. A change at any other time leaves the running period's output unchanged.
- R3: In every full period with captured duty D, `pwm_out` is high from the period's first clock for D+1 consecutive clocks and low for the remaining clocks.
- R4: With D equal to all ones, the simultaneous set and clear resolve in favour of set. `pwm_out` stays high for every clock of the period, with no low cycle between consecutive full-duty periods.
- R5: With D equal to zero, `pwm_out` is high for exactly one clock per period, the period's first.
- R6: `period_start` is high for exactly one clock per full period: the first clock, when the counter is zero and `pwm_out` has just risen.
- R7: A synchronous active-high `rst` clears the counter to zero and drives `pwm_out` and `period_start` low. During the first 2^WIDTH clocks after release, both outputs stay low. The first full period starts 2^WIDTH clocks after release.
- R8: `rst` takes priority over the set/reset cell. Asserting it while `pwm_out` is high drives the output low at the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| duty_in | input | WIDTH | Duty word; high time is duty_in+1 clocks out of 2^WIDTH |
| pwm_out | output | 1 | PWM output from the set/reset cell |
| period_start | output | 1 | One-clock strobe on the first clock of each full period |

## Verification
The bench builds the block with WIDTH = 5, which gives a 32-clock period. This makes it cheap to sweep every duty value, both ascending and descending. It also covers back-to-back transitions between zero and all-ones duty, where the set/clear collision and the single-clock pulse sit next to each other. Each period also drives a mid-period value onto `duty_in` that must be ignored. The bench checks the output and strobe on every clock against a cycle-indexed arithmetic model. The sweep ends with a reset applied during a high phase, followed by a fresh start-up.

// File: rtl/pwmg_pkg.sv
package pwmg_pkg;

  // Action the set/reset cell takes on a clock edge.
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_SET   = 2'd1,
    ACT_CLEAR = 2'd2
  } sr_act_e;

  // Clear request qualified by the wrap event: a match coinciding with
  // the wrap is dropped so the set path alone acts in that cycle.
  function automatic logic gate_clear(input logic match, input logic wrap);
    return match & ~wrap;
  endfunction

  // Set has priority; the gating above already keeps both from rising.
  function automatic sr_act_e pick_action(input logic set_req, input logic clr_req);
    if (set_req)      return ACT_SET;
    else if (clr_req) return ACT_CLEAR;
    else              return ACT_HOLD;
  endfunction

  function automatic logic apply_action(input sr_act_e act, input logic cur);
    case (act)
      ACT_SET:   return 1'b1;
      ACT_CLEAR: return 1'b0;
      default:   return cur;
    endcase
  endfunction

endpackage

// File: rtl/pwmg_counter.sv
// Free-running up-counter with terminal decode and period strobe.
module pwmg_counter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  output logic [WIDTH-1:0] count_o,
  output logic             wrap_o,
  output logic             start_o
);
  localparam logic [WIDTH-1:0] TOP  = '1;
  localparam logic [WIDTH-1:0] ZERO = '0;
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_o <= ZERO;
      armed_q <= 1'b0;
    end else begin
      count_o <= count_o + ONE;
      if (wrap_o) armed_q <= 1'b1;
    end
  end

  assign wrap_o  = (count_o == TOP);
  // Strobe only once a complete period has begun after reset.
  assign start_o = armed_q & (count_o == ZERO);

endmodule

// File: rtl/pwmg_match.sv
// Bitwise equality comparator between counter and captured duty.
module pwmg_match #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             eq_o
);
  logic [WIDTH-1:0] same;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign same[i] = ~(a_i[i] ^ b_i[i]);
  end

  assign eq_o = &same;

endmodule

// File: rtl/pwmg_duty_hold.sv
// Captures the duty word on the last clock of each period.
module pwmg_duty_hold #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [WIDTH-1:0] duty_i,
  output logic [WIDTH-1:0] duty_q
);
  always_ff @(posedge clk) begin
    if (rst)         duty_q <= '0;
    else if (load_i) duty_q <= duty_i;
  end

endmodule

// File: rtl/pwmg_sr_cell.sv
// Clocked set/reset cell producing the PWM level.
module pwmg_sr_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  import pwmg_pkg::*;

  sr_act_e act;

  always_comb act = pick_action(set_i, clr_i);

  always_ff @(posedge clk) begin
    if (rst) q_o <= 1'b0;
    else     q_o <= apply_action(act, q_o);
  end

endmodule

// File: rtl/pwm_cmp_gen.sv
// Counter-compare PWM generator top.
module pwm_cmp_gen #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] duty_in,
  output logic             pwm_out,
  output logic             period_start
);
  import pwmg_pkg::*;

  // Named internal events, brought out for the checker.
  logic [WIDTH-1:0] cnt_w;
  logic [WIDTH-1:0] duty_q_w;
  logic             wrap_w;
  logic             match_w;
  logic             set_w;
  logic             clr_w;

  pwmg_counter #(.WIDTH(WIDTH)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .count_o (cnt_w),
    .wrap_o  (wrap_w),
    .start_o (period_start)
  );

  pwmg_duty_hold #(.WIDTH(WIDTH)) u_duty (
    .clk    (clk),
    .rst    (rst),
    .load_i (wrap_w),
    .duty_i (duty_in),
    .duty_q (duty_q_w)
  );

  pwmg_match #(.WIDTH(WIDTH)) u_cmp (
    .a_i  (cnt_w),
    .b_i  (duty_q_w),
    .eq_o (match_w)
  );

  always_comb begin
    set_w = wrap_w;
    clr_w = gate_clear(match_w, wrap_w);
  end

  pwmg_sr_cell u_sr (
    .clk   (clk),
    .rst   (rst),
    .set_i (set_w),
    .clr_i (clr_w),
    .q_o   (pwm_out)
  );

endmodule

// File: rtl/pwm_cmp_gen_chk.sv
module pwm_cmp_gen_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] cnt,
  input logic [WIDTH-1:0] duty_q,
  input logic             wrap,
  input logic             set_ev,
  input logic             clr_ev,
  input logic             pwm,
  input logic             strobe
);
  localparam logic [WIDTH-1:0] TOP = '1;

  // R4: set and clear never reach the cell together
  a_r4_no_collision: assert property (@(posedge clk) disable iff (rst)
    !(set_ev && clr_ev));

  // R1: counter steps by one below the terminal value
  a_r1_count_step: assert property (@(posedge clk) disable iff (rst)
    (cnt != TOP) |=> (cnt == $past(cnt) + WIDTH'(1)));

  // R1: counter wraps to zero from the terminal value
  a_r1_count_wrap: assert property (@(posedge clk) disable iff (rst)
    (cnt == TOP) |=> (cnt == '0));

  // R2: captured duty changes only across a wrap
  a_r2_duty_stable: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(duty_q));

  // R3: a set event raises the output
  a_r3_set_rises: assert property (@(posedge clk) disable iff (rst)
    set_ev |=> pwm);

  // R3: a clear event lowers the output
  a_r3_clr_falls: assert property (@(posedge clk) disable iff (rst)
    clr_ev |=> !pwm);

  // R3: without events the output holds
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!set_ev && !clr_ev) |=> $stable(pwm));

  // R6: the strobe marks counter zero with the output just raised
  a_r6_strobe_at_zero: assert property (@(posedge clk) disable iff (rst)
    strobe |-> (cnt == '0 && pwm));

  // R7, R8: reset forces the output low and the counter to zero
  a_r7_reset_state: assert property (@(posedge clk)
    rst |=> (!pwm && !strobe && cnt == '0));

endmodule

bind pwm_cmp_gen pwm_cmp_gen_chk #(.WIDTH(WIDTH)) chk_i (
  .clk    (clk),
  .rst    (rst),
  .cnt    (cnt_w),
  .duty_q (duty_q_w),
  .wrap   (wrap_w),
  .set_ev (set_w),
  .clr_ev (clr_w),
  .pwm    (pwm_out),
  .strobe (period_start)
);

// File: tb/pwm_cmp_gen_tb_top.sv
module pwm_cmp_gen_tb_top;
  localparam int W    = 5;
  localparam int P    = 1 << W;
  localparam int MAXV = P - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] duty = '0;
  logic         pwm;
  logic         strobe;

  always #5 clk = ~clk;

  pwm_cmp_gen #(.WIDTH(W)) dut_i (
    .clk          (clk),
    .rst          (rst),
    .duty_in      (duty),
    .pwm_out      (pwm),
    .period_start (strobe)
  );

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;
  int  n;           // clocks since reset release
  int  cur_d;       // duty in force for the running period
  int  pending;     // duty committed for the next period
  int  last_strobe;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, n);
    end
  endtask

  // Duty schedule: ascending sweep, descending sweep, then 0/all-ones toggling.
  function automatic int commit_for(input int idx);
    if (idx <= P)          return idx - 1;
    else if (idx <= 2 * P) return 2 * P - idx;
    else                   return (idx % 2 == 1) ? MAXV : 0;
  endfunction

  // One clock: check outputs against the model, then drive duty.
  task automatic step();
    int k;
    int m;
    int exp_p;
    int exp_s;
    string tag;
    @(negedge clk);
    n++;
    k = n % P;
    m = n / P;
    if (k == 0 && m >= 1) begin
      cur_d = pending;
      if (m >= 2) chk("R1 period length", n - last_strobe, P);
      last_strobe = n;
    end
    exp_s = (m >= 1 && k == 0) ? 1 : 0;
    chk("R6 period_start", int'(strobe), exp_s);
    exp_p = (m >= 1 && k <= cur_d) ? 1 : 0;
    if (m == 0)              tag = "R7 start-up period output";
    else if (cur_d == MAXV)  tag = "R4 full duty";
    else if (cur_d == 0)     tag = "R5 minimum duty";
    else                     tag = "R3 high time";
    if (m >= 1 && k > P / 2) tag = {tag, " after mid-period change R2"};
    chk(tag, int'(pwm), exp_p);
    // Mid-period disturbance that must not affect the running period (R2).
    if (k == P / 2) duty = W'(MAXV - cur_d);
    if (k == P - 1) begin
      pending = commit_for(m + 1);
      duty    = W'(pending);
    end
  endtask

  task automatic start_run();
    rst = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk("R7 reset pwm_out", int'(pwm), 0);
      chk("R7 reset period_start", int'(strobe), 0);
    end
    rst         = 1'b0;
    n           = 0;
    cur_d       = 0;
    pending     = 0;
    last_strobe = 0;
  endtask

  initial begin
    start_run();
    repeat ((2 * P + 6) * P) step();
    // Reach a high phase of a full-duty period, then reset (R8).
    while (!((n % P) == 2 && cur_d == MAXV && n >= P)) step();
    rst = 1'b1;
    @(negedge clk);
    chk("R8 reset during high phase pwm_out", int'(pwm), 0);
    chk("R8 reset during high phase period_start", int'(strobe), 0);
    start_run();
    repeat (4 * P) step();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule